// File: doc/BRIEF.md
# Pin-Strapped Serial Bus Slave Front End

This block is the bus-facing half of a small sensor device on a two-wire SMBus/I2C-style bus. Both bus lines are sampled with the system clock and pass through a short synchronizer. From the sampled values the block recognises start and stop conditions and shifts bits in or out on the host's clock. Every transfer is one address byte followed by one data byte. The block acknowledges an address only when it matches its own address. After a write address it takes one byte, acknowledges it and hands it to user logic. After a read address it asks user logic for one byte and shifts that byte out.

The device address is not a build-time constant. It comes from two strap inputs. Each strap carries a tri-level state (tied low, left open, tied high) as a two-bit code. The pair selects one of nine fixed 7-bit addresses. The decoded address is captured once, on the first clock after reset is released, and later changes on the straps have no effect. The block never drives the clock line. On the data line it only pulls low, through an open-drain enable.

Top module: `smb_strap_slave`

## Requirements
- R1: The block treats a falling SDA with SCL high as START and a rising SDA with SCL high as STOP. While idle, bits clocked on the bus without a preceding START draw no acknowledge and no write strobe.
- R2: Bits are taken on rising SCL and shifted MSB first. In the first byte after START, bits 7..1 are the address and bit 0 is the direction (1 = read, 0 = write).
- R3: The block holds `sda_pull_o` high for the whole high phase of the ninth clock, but only when the address matches. With a mismatched address it leaves SDA released and ignores the bus until the next START.
- R4: Strap codes are 00 = low, 01 = open, 10 = high, and 11 counts as open. With `strap0_i` low, `strap1_i` low/open/high selects 0x18/0x19/0x1A. With `strap0_i` open it selects 0x29/0x2A/0x2B. With `strap0_i` high it selects 0x4C/0x4D/0x4E.
- R5: The address is latched on the first clock after reset is released. Strap changes after that point do not change the address that is answered.
- R6: After a matched write address, the block takes exactly one data byte, acknowledges it, and pulses `wr_strobe_o` for one clock with the byte on `wr_data_o`.
- R7: When a read address is acknowledged, `rd_req_o` pulses for one clock, in the same clock that `sda_pull_o` rises, and `rd_data_i` is captured in that clock. The byte is then driven MSB first. `sda_pull_o` changes only while the synchronized SCL is low.
- R8: After the eighth read bit, the block releases SDA, samples the host's response on the ninth clock and returns to idle. After a NACK it takes no further part until the next START.
- R9: A START at any point abandons the current transfer and begins a new address byte. A STOP at any point abandons the transfer and returns to idle.
- R10: While reset is asserted, `sda_pull_o`, `wr_strobe_o` and `rd_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap0_i | input | 2 | First tri-level address strap (00 low, 01 open, 10 high, 11 open) |
| strap1_i | input | 2 | Second tri-level address strap, same encoding |
| rd_data_i | input | 8 | Byte to send on a read, captured when `rd_req_o` pulses |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_strobe_o | output | 1 | One-clock pulse when a written byte is accepted |
| wr_data_o | output | 8 | The accepted written byte |
| rd_req_o | output | 1 | One-clock pulse when a read address is acknowledged |

## Verification
The case that is hardest to bring about from the ports is the frozen strap latch. The answered address can only be seen by changing the strap pins after reset and then showing that the old address still draws an acknowledge and the new one does not. The bench resets under one strap setting and moves the straps while the bus is idle. It then runs one write to each address. It also walks all sixteen strap code pairs, including the code-11 aliases, with a reset before each, and confirms both the acknowledge and the delivered byte. Aborts are provoked by issuing a second START halfway through an address byte, and by issuing a STOP between an acknowledged address and its data byte.

// File: rtl/smbs_pkg.sv
package smbs_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);

    // Sampled bus view with derived events
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_DEC,
        PH_ADDR_ACK,
        PH_WR,
        PH_WR_DEC,
        PH_WR_ACK,
        PH_RD,
        PH_RD_CHK
    } phase_e;

    // Tri-level strap code to level index 0..2; code 11 aliases open
    function automatic logic [1:0] strap_level(input logic [1:0] code);
        return (code == 2'b11) ? 2'b01 : code;
    endfunction

    // Nine-entry address decode: base picked by strap0, offset by strap1
    function automatic logic [ADDR_W-1:0] strap_addr(input logic [1:0] s0,
                                                     input logic [1:0] s1);
        logic [ADDR_W-1:0] base;
        case (strap_level(s0))
            2'b00:   base = 7'h18;
            2'b01:   base = 7'h29;
            default: base = 7'h4C;
        endcase
        return base + {{(ADDR_W-2){1'b0}}, strap_level(s1)};
    endfunction

endpackage

// File: rtl/smbs_sync.sv
module smbs_sync
    import smbs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
            end
        end
        assign cur[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '1;
        end else begin
            prev <= cur;
        end
    end

    always_comb begin
        ev.scl      = cur[1];
        ev.sda      = cur[0];
        ev.scl_rise = cur[1] & ~prev[1];
        ev.scl_fall = ~cur[1] & prev[1];
        ev.start    = cur[1] & prev[1] & prev[0] & ~cur[0];
        ev.stop     = cur[1] & prev[1] & ~prev[0] & cur[0];
    end

endmodule

// File: rtl/smbs_strap.sv
module smbs_strap
    import smbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap0_i,
    input  logic [1:0]        strap1_i,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              addr_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_addr   <= '0;
            addr_valid <= 1'b0;
        end else if (!addr_valid) begin
            dev_addr   <= strap_addr(strap0_i, strap1_i);
            addr_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/smbs_engine.sv
module smbs_engine
    import smbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              addr_valid,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sda_pull_o,
    output logic              wr_strobe_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_req_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    phase_e            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              is_read;
    logic              addr_hit;

    assign addr_hit = addr_valid && (shreg[DATA_W-1:1] == dev_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            is_read     <= 1'b0;
            sda_pull_o  <= 1'b0;
            wr_strobe_o <= 1'b0;
            wr_data_o   <= '0;
            rd_req_o    <= 1'b0;
        end else begin
            wr_strobe_o <= 1'b0;
            rd_req_o    <= 1'b0;
            if (ev.start) begin
                phase      <= PH_ADDR;
                bit_cnt    <= '0;
                sda_pull_o <= 1'b0;
            end else if (ev.stop) begin
                phase      <= PH_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR: begin
                        if (ev.scl_rise) begin
                            shreg   <= {shreg[DATA_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) phase <= PH_ADDR_DEC;
                        end
                    end
                    PH_ADDR_DEC: begin
                        if (ev.scl_fall) begin
                            if (addr_hit) begin
                                is_read    <= shreg[0];
                                sda_pull_o <= 1'b1;
                                phase      <= PH_ADDR_ACK;
                                if (shreg[0]) begin
                                    shreg    <= rd_data_i;
                                    rd_req_o <= 1'b1;
                                end
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                sda_pull_o <= ~shreg[DATA_W-1];
                                phase      <= PH_RD;
                            end else begin
                                sda_pull_o <= 1'b0;
                                phase      <= PH_WR;
                            end
                        end
                    end
                    PH_WR: begin
                        if (ev.scl_rise) begin
                            shreg   <= {shreg[DATA_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) phase <= PH_WR_DEC;
                        end
                    end
                    PH_WR_DEC: begin
                        if (ev.scl_fall) begin
                            wr_strobe_o <= 1'b1;
                            wr_data_o   <= shreg;
                            sda_pull_o  <= 1'b1;
                            phase       <= PH_WR_ACK;
                        end
                    end
                    PH_WR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull_o <= 1'b0;
                            phase      <= PH_IDLE;
                        end
                    end
                    PH_RD: begin
                        if (ev.scl_fall) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                sda_pull_o <= 1'b0;
                                phase      <= PH_RD_CHK;
                            end else begin
                                shreg      <= {shreg[DATA_W-2:0], 1'b0};
                                sda_pull_o <= ~shreg[DATA_W-2];
                            end
                        end
                    end
                    PH_RD_CHK: begin
                        // host response sampled on the ninth rise; either way the byte is done
                        if (ev.scl_rise) phase <= PH_IDLE;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_strap_slave.sv
module smb_strap_slave
    import smbs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap0_i,
    input  logic [1:0]        strap1_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sda_pull_o,
    output logic              wr_strobe_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_req_o
);

    bus_ev_t           bus_ev;
    logic [ADDR_W-1:0] dev_addr;
    logic              addr_valid;

    smbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (bus_ev)
    );

    smbs_strap u_strap (
        .clk        (clk),
        .rst        (rst),
        .strap0_i   (strap0_i),
        .strap1_i   (strap1_i),
        .dev_addr   (dev_addr),
        .addr_valid (addr_valid)
    );

    smbs_engine u_engine (
        .clk         (clk),
        .rst         (rst),
        .ev          (bus_ev),
        .dev_addr    (dev_addr),
        .addr_valid  (addr_valid),
        .rd_data_i   (rd_data_i),
        .sda_pull_o  (sda_pull_o),
        .wr_strobe_o (wr_strobe_o),
        .wr_data_o   (wr_data_o),
        .rd_req_o    (rd_req_o)
    );

endmodule

// File: rtl/smbs_checker.sv
module smbs_checker (
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       sda_pull_o,
    input logic       wr_strobe_o,
    input logic       rd_req_o,
    input logic       addr_valid,
    input logic [6:0] dev_addr
);

    // R10: outputs quiet in the clock after reset is seen
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_pull_o && !wr_strobe_o && !rd_req_o));

    // R6: write strobe lasts one clock
    a_r6_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_strobe_o |=> !wr_strobe_o);

    // R7: read request lasts one clock
    a_r7_rdreq_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> !rd_req_o);

    // R7: read request coincides with the address acknowledge
    a_r7_rdreq_acks: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> sda_pull_o);

    // R7, R3: the data line enable moves only while the sampled clock is low
    a_r7_sda_moves_low_scl: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_s);

    // R5: once latched, the address never changes
    a_r5_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && $past(addr_valid)) |-> $stable(dev_addr));

endmodule

bind smb_strap_slave smbs_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_s       (bus_ev.scl),
    .sda_pull_o  (sda_pull_o),
    .wr_strobe_o (wr_strobe_o),
    .rd_req_o    (rd_req_o),
    .addr_valid  (addr_valid),
    .dev_addr    (dev_addr)
);

// File: tb/tb_smb_strap_slave.sv
`timescale 1ns/1ps
module tb_smb_strap_slave;

    localparam int H = 20;   // system clocks per SCL phase

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic [1:0] strap0 = 2'b00;
    logic [1:0] strap1 = 2'b00;
    logic [7:0] rd_data = 8'h00;
    logic       sda_pull;
    logic       wr_strobe;
    logic [7:0] wr_data;
    logic       rd_req;

    int n_chk = 0;
    int n_fail = 0;
    int rd_req_cnt = 0;
    bit done = 0;
    logic [7:0] exp_wr[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    smb_strap_slave dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .strap0_i    (strap0),
        .strap1_i    (strap1),
        .rd_data_i   (rd_data),
        .sda_pull_o  (sda_pull),
        .wr_strobe_o (wr_strobe),
        .wr_data_o   (wr_data),
        .rd_req_o    (rd_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: each write strobe pops one expected byte
    always @(negedge clk) begin
        if (!rst && rd_req) rd_req_cnt++;
        if (!rst && wr_strobe) begin
            if (exp_wr.size() == 0) begin
                chk("R6 unexpected write strobe", {24'd0, wr_data}, 32'hFFFF_FFFF);
            end else begin
                chk("R6 written byte", {24'd0, wr_data}, {24'd0, exp_wr.pop_front()});
            end
        end
    end

    function automatic logic [6:0] model_addr(input logic [1:0] c0, input logic [1:0] c1);
        logic [1:0] l0 = (c0 == 2'b11) ? 2'b01 : c0;
        logic [1:0] l1 = (c1 == 2'b11) ? 2'b01 : c1;
        case ({l0, l1})
            4'b0000: return 7'b0011000;
            4'b0001: return 7'b0011001;
            4'b0010: return 7'b0011010;
            4'b0100: return 7'b0101001;
            4'b0101: return 7'b0101010;
            4'b0110: return 7'b0101011;
            4'b1000: return 7'b1001100;
            4'b1001: return 7'b1001101;
            default: return 7'b1001110;
        endcase
    endfunction

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] c0, input logic [1:0] c1);
        strap0 = c0; strap1 = c1;
        scl = 1'b1; sda_m = 1'b1;
        rst = 1'b1;
        waitc(4);
        rst = 1'b0;
        waitc(4);
    endtask

    task automatic bus_start;
        scl = 1'b0; waitc(4);
        sda_m = 1'b1; waitc(H);
        scl = 1'b1; waitc(H);
        sda_m = 1'b0; waitc(H);
        scl = 1'b0;
    endtask

    task automatic bus_stop;
        scl = 1'b0; waitc(4);
        sda_m = 1'b0; waitc(H);
        scl = 1'b1; waitc(H);
        sda_m = 1'b1; waitc(H);
    endtask

    task automatic put_bit(input logic b);
        waitc(4);
        sda_m = b;
        waitc(H - 4);
        scl = 1'b1; waitc(H);
        scl = 1'b0;
    endtask

    task automatic get_bit(output logic v);
        sda_m = 1'b1;
        waitc(H);
        scl = 1'b1; waitc(H / 2);
        v = sda_line;
        waitc(H / 2);
        scl = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic get_byte(input logic host_nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(host_nack);
    endtask

    // Driver: one write transfer; pushes the expected byte when an acknowledge is expected
    task automatic wr_xfer(input string tag, input logic [6:0] a, input logic [7:0] d,
                           input logic expect_ack);
        logic ack;
        bus_start();
        put_byte({a, 1'b0}, ack);
        chk({tag, " address ack"}, {31'd0, ack}, {31'd0, expect_ack});
        if (expect_ack) exp_wr.push_back(d);
        put_byte(d, ack);
        chk({tag, " data ack"}, {31'd0, ack}, {31'd0, expect_ack});
        bus_stop();
    endtask

    initial begin
        logic       ack;
        logic       v;
        logic [7:0] got;
        int         base;

        // R10: reset state
        rst = 1'b1;
        waitc(3);
        chk("R10 pull in reset", {31'd0, sda_pull}, 32'd0);
        chk("R10 strobes in reset", {30'd0, wr_strobe, rd_req}, 32'd0);

        // R4, R6, R3, R2: every strap code pair, matched and mismatched address
        for (int c = 0; c < 16; c++) begin
            logic [1:0] c0 = 2'(c >> 2);
            logic [1:0] c1 = 2'(c);
            logic [6:0] a  = model_addr(c0, c1);
            do_reset(c0, c1);
            wr_xfer($sformatf("R4 strap %0d%0d", c0, c1), a, 8'(8'h30 + c * 7), 1'b1);
            wr_xfer("R3 mismatch", a ^ 7'h20, 8'hEE, 1'b0);
        end

        // R5: straps move after the latch; old address still answered
        do_reset(2'b10, 2'b00);
        strap0 = 2'b00; strap1 = 2'b00;
        waitc(10);
        wr_xfer("R5 old address", 7'h4C, 8'h5A, 1'b1);
        wr_xfer("R5 new address", 7'h18, 8'h66, 1'b0);

        // R1: bits without START draw nothing
        scl = 1'b0; waitc(H);
        for (int i = 7; i >= 0; i--) put_bit(i == 0 ? 1'b0 : (7'h4C >> (i - 1)) & 1'b1);
        get_bit(v);
        chk("R1 no ack without START", {31'd0, v}, 32'd1);
        bus_stop();

        // R7, R8: read with host NACK
        rd_data = 8'hA5;
        base = rd_req_cnt;
        bus_start();
        put_byte({7'h4C, 1'b1}, ack);
        chk("R7 read address ack", {31'd0, ack}, 32'd1);
        chk("R7 one read request", rd_req_cnt - base, 32'd1);
        rd_data = 8'h00;
        get_byte(1'b1, got);
        chk("R7 read byte MSB first", {24'd0, got}, 32'hA5);
        waitc(6);
        chk("R8 released after NACK", {31'd0, sda_pull}, 32'd0);
        put_bit(1'b1);
        chk("R8 still released", {31'd0, sda_pull}, 32'd0);
        bus_stop();

        // R7, R8: read with host ACK on the ninth clock
        rd_data = 8'h3C;
        bus_start();
        put_byte({7'h4C, 1'b1}, ack);
        get_byte(1'b0, got);
        chk("R7 second read byte", {24'd0, got}, 32'h3C);
        waitc(6);
        chk("R8 released after ninth bit", {31'd0, sda_pull}, 32'd0);
        bus_stop();

        // R9: repeated START in the middle of an address byte
        bus_start();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        put_byte({7'h4C, 1'b0}, ack);
        chk("R9 restart address ack", {31'd0, ack}, 32'd1);
        exp_wr.push_back(8'hC3);
        put_byte(8'hC3, ack);
        chk("R9 restart data ack", {31'd0, ack}, 32'd1);
        bus_stop();

        // R9: STOP after the address acknowledge abandons the write
        bus_start();
        put_byte({7'h4C, 1'b0}, ack);
        chk("R9 address before stop", {31'd0, ack}, 32'd1);
        bus_stop();
        scl = 1'b0; waitc(H);
        put_byte(8'h77, ack);
        chk("R9 no data ack after STOP", {31'd0, ack}, 32'd0);
        bus_stop();

        waitc(20);
        chk("R6 scoreboard drained", exp_wr.size(), 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule